// File: doc/BRIEF.md
# Serial Control and Status Exchange Port

This block is a byte-wide, full-duplex serial port for a host processor. While the host holds chip select low, it clocks eight bits in and eight bits out. The bits it sends become the new control byte. The bits it receives are a status byte that was captured when chip select fell. There is no separate read command: every complete transfer writes the control register. A host that only wants to poll status therefore sends the current control value back.

The block also drives an active-low interrupt line. The interrupt latches when the line-detect or sync status input changes level. It is released by the first serial clock of the next transfer. A third status bit records coding violations reported as single-cycle pulses. That bit is sticky, never raises the interrupt, and is cleared by every chip-select pulse, so a host that polls it regularly can measure an error rate.

The serial pins are oversampled by the block's system clock. Each one passes through a synchronizer followed by an edge detector, so the whole block runs in one clock domain. The serial output is paired with an enable signal in place of a tristate driver.

Top module: `serial_ctl_port`

## Requirements
- R1: After reset, the control byte is 0x00, the interrupt output is high and the serial output enable is low.
- R2: A transfer with exactly 8 serial clock rising edges while chip select is low loads the control byte when chip select rises. The first bit received lands in bit 7 and the last in bit 0.
- R3: A transfer with any other number of rising edges (fewer or more than 8) leaves the control byte unchanged.
- R4: The serial output presents the status byte MSB first. Bit 7 appears once chip select falls, and each serial clock falling edge advances one bit. The status byte has bit 0 = line detect, bit 1 = sync, bit 2 = violation flag and bits 7..3 = 0.
- R5: The status byte is captured when chip select falls. Status input changes during a transfer do not alter the bits shifted out.
- R6: The serial output enable is high while chip select is low and low while chip select is high.
- R7: A change in level of line detect or sync drives the interrupt output low, and it stays low until released.
- R8: The interrupt is released by the first serial clock rising edge inside a transfer. A chip-select pulse with no serial clock does not release it.
- R9: A violation pulse sets status bit 2 and does not drive the interrupt low.
- R10: Status bit 2 is cleared on every chip-select falling edge, so the following transfer reads 0 unless a new violation occurs.
- R11: Serial clock edges and data while chip select is high have no effect on the control byte or on the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in, sampled on sclk rising edges |
| sdo | output | 1 | Serial data out, advanced on sclk falling edges |
| sdo_en | output | 1 | Drive enable for sdo, high during a transfer |
| irq_n | output | 1 | Latched active-low interrupt |
| line_det | input | 1 | Line-detect status level |
| in_sync | input | 1 | Synchronized status level |
| viol_pulse | input | 1 | One-cycle pulse per received coding violation |
| ctrl_q | output | 8 | Current control byte |

## Verification
The hardest cases to reach are status activity that overlaps a transfer. The first is a level change that arrives after the first serial clock has released the interrupt: the interrupt must latch again, while the byte already being shifted out stays as it was captured. The second is a violation pulse landing among interrupt-setting changes. The stimulus reaches the first case by toggling line detect partway through a transfer, at a chosen clock index, and reaches the second by placing violation pulses between randomized status updates. Partial and overlong transfers are mixed into the random sequence so that rejected loads are exercised next to accepted ones.

// File: rtl/cxp_pkg.sv
package cxp_pkg;

    localparam int BYTE_W    = 8;
    localparam int ST_LINE   = 0;
    localparam int ST_SYNC   = 1;
    localparam int ST_VIOL   = 2;

    // Decoded pin activity, one system clock wide per event
    typedef struct packed {
        logic sel;       // chip select asserted (synchronized level)
        logic sel_fall;
        logic sel_rise;
        logic clk_rise;
        logic clk_fall;
        logic din;
    } pin_ev_t;

    function automatic logic [BYTE_W-1:0] pack_status(input logic ld,
                                                      input logic sy,
                                                      input logic vi);
        logic [BYTE_W-1:0] s;
        s          = '0;
        s[ST_LINE] = ld;
        s[ST_SYNC] = sy;
        s[ST_VIOL] = vi;
        return s;
    endfunction

endpackage

// File: rtl/cxp_sync.sv
module cxp_sync
    import cxp_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    cs_n,
    input  logic    sclk,
    input  logic    sdi,
    output pin_ev_t ev
);
    localparam int PW = 3;
    localparam logic [PW-1:0] IDLE = 3'b100; // {cs_n, sclk, sdi}

    logic [PW-1:0] stage [STAGES];
    logic [PW-1:0] last;
    logic [PW-1:0] cur;

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage[k] <= IDLE;
                end else if (k == 0) begin
                    stage[k] <= {cs_n, sclk, sdi};
                end else begin
                    stage[k] <= stage[(k == 0) ? 0 : k-1];
                end
            end
        end
    endgenerate

    assign cur = stage[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) last <= IDLE;
        else     last <= cur;
    end

    always_comb begin
        ev.sel      = !cur[2];
        ev.sel_fall = last[2] && !cur[2];
        ev.sel_rise = !last[2] && cur[2];
        ev.clk_rise = !last[1] && cur[1];
        ev.clk_fall = last[1] && !cur[1];
        ev.din      = cur[0];
    end

endmodule

// File: rtl/cxp_shifter.sv
module cxp_shifter
    import cxp_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  pin_ev_t      ev,
    input  logic [W-1:0] snap_in,
    output logic [W-1:0] ctrl,
    output logic         sdo,
    output logic         sdo_en,
    output logic         first_clk
);
    localparam int CW = $clog2(W + 2);
    localparam logic [CW-1:0] FULL = CW'(W);
    localparam logic [CW-1:0] SAT  = {CW{1'b1}};

    logic          active;
    logic [CW-1:0] cnt;
    logic [W-1:0]  rx;
    logic [W-1:0]  tx;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            rx     <= '0;
            tx     <= '0;
            ctrl   <= '0;
        end else if (ev.sel_fall) begin
            active <= 1'b1;
            cnt    <= '0;
            tx     <= snap_in;
        end else if (active) begin
            if (ev.sel_rise) begin
                active <= 1'b0;
                if (cnt == FULL) ctrl <= rx;
            end else begin
                if (ev.clk_rise) begin
                    rx <= {rx[W-2:0], ev.din};
                    if (cnt != SAT) cnt <= cnt + 1'b1;
                end
                if (ev.clk_fall) tx <= {tx[W-2:0], 1'b0};
            end
        end
    end

    assign sdo       = tx[W-1];
    assign sdo_en    = active;
    assign first_clk = active && !ev.sel_rise && ev.clk_rise && (cnt == '0);

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        (active && ev.sel_rise && cnt == FULL) |=> (ctrl == $past(rx)));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (ev.sel_rise && cnt != FULL) |=> $stable(ctrl));

    p_en_on_r6: assert property (@(posedge clk) disable iff (rst)
        ev.sel_fall |=> sdo_en);

    p_en_off_r6: assert property (@(posedge clk) disable iff (rst)
        (ev.sel_rise && !ev.sel_fall) |=> !sdo_en);

    p_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (!active && !ev.sel_fall) |=> ($stable(rx) && $stable(ctrl)));

endmodule

// File: rtl/cxp_status.sv
module cxp_status
    import cxp_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  pin_ev_t      ev,
    input  logic         line_det,
    input  logic         in_sync,
    input  logic         viol_pulse,
    input  logic         first_clk,
    output logic [W-1:0] stat_now,
    output logic         irq
);
    typedef struct packed {
        logic ld;
        logic sy;
    } lvl_t;

    lvl_t seen;
    logic sticky;
    logic chg;

    assign chg = (seen.ld != line_det) || (seen.sy != in_sync);

    always_ff @(posedge clk) begin
        if (rst) begin
            seen   <= '0;
            sticky <= 1'b0;
            irq    <= 1'b0;
        end else begin
            seen.ld <= line_det;
            seen.sy <= in_sync;
            if (ev.sel_fall)     sticky <= 1'b0;
            else if (viol_pulse) sticky <= 1'b1;
            if (chg)             irq <= 1'b1;
            else if (first_clk)  irq <= 1'b0;
        end
    end

    assign stat_now = pack_status(seen.ld, seen.sy, sticky | viol_pulse);

    p_set_r7: assert property (@(posedge clk) disable iff (rst)
        chg |=> irq);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (irq && !first_clk) |=> irq);

    p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!irq && !chg) |=> !irq);

    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        ev.sel_fall |=> !sticky);

endmodule

// File: rtl/serial_ctl_port.sv
module serial_ctl_port
    import cxp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_en,
    output logic              irq_n,
    input  logic              line_det,
    input  logic              in_sync,
    input  logic              viol_pulse,
    output logic [BYTE_W-1:0] ctrl_q
);
    pin_ev_t           ev;
    logic [BYTE_W-1:0] stat_now;
    logic              first_clk;
    logic              irq;

    cxp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .sclk (sclk),
        .sdi  (sdi),
        .ev   (ev)
    );

    cxp_shifter #(.W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .snap_in   (stat_now),
        .ctrl      (ctrl_q),
        .sdo       (sdo),
        .sdo_en    (sdo_en),
        .first_clk (first_clk)
    );

    cxp_status #(.W(BYTE_W)) u_stat (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .line_det   (line_det),
        .in_sync    (in_sync),
        .viol_pulse (viol_pulse),
        .first_clk  (first_clk),
        .stat_now   (stat_now),
        .irq        (irq)
    );

    assign irq_n = !irq;

    p_rst_r1: assert property (@(posedge clk)
        $past(rst) |-> (irq_n && !sdo_en && ctrl_q == '0));

endmodule

// File: tb/test_serial_ctl_port.sv
module test_serial_ctl_port;
    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic       line_det = 1'b0, in_sync = 1'b0, viol_pulse = 1'b0;
    logic       sdo, sdo_en, irq_n;
    logic [7:0] ctrl_q;

    int checks = 0, fails = 0;
    bit done = 0;

    bit         m_ld = 0, m_sy = 0, m_vi = 0, m_irq = 0;
    logic [7:0] m_ctrl = 8'h00;

    always #10 clk = ~clk;

    serial_ctl_port i_serial_ctl_port (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_en(sdo_en), .irq_n(irq_n), .line_det(line_det),
        .in_sync(in_sync), .viol_pulse(viol_pulse), .ctrl_q(ctrl_q)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_stat(input bit ld, input bit sy, input bit vi);
        return {5'b0, vi, sy, ld};
    endfunction

    function automatic logic [7:0] top_mask(input int n);
        logic [7:0] m = '0;
        for (int i = 0; i < 8 && i < n; i++) m[7-i] = 1'b1;
        return m;
    endfunction

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_status(input bit ld, input bit sy);
        if (ld != m_ld || sy != m_sy) m_irq = 1;
        m_ld = ld; m_sy = sy;
        line_det = ld; in_sync = sy;
        wclk(5);
    endtask

    task automatic pulse_viol();
        @(negedge clk) viol_pulse = 1'b1;
        @(negedge clk) viol_pulse = 1'b0;
        m_vi = 1;
        wclk(4);
    endtask

    // chg_at: clock index after whose falling edge line_det toggles (-1: none)
    task automatic xfer(input logic [7:0] din, input int n, input int chg_at);
        logic [7:0] dout = '0;
        logic [7:0] exp = exp_stat(m_ld, m_sy, m_vi);
        logic [7:0] msk = top_mask(n);
        m_vi = 0;
        @(negedge clk) cs_n = 1'b0;
        wclk(6);
        chk(sdo_en === 1'b1, "R6 enable during transfer", sdo_en, 1);
        for (int i = 0; i < n; i++) begin
            if (i < 8) dout[7-i] = sdo;
            sdi = (i < 8) ? din[7-i] : 1'b0;
            wclk(HALF);
            sclk = 1'b1;
            if (i == 0) m_irq = 0;
            wclk(HALF);
            sclk = 1'b0;
            wclk(HALF);
            if (i == chg_at) begin
                m_ld = !m_ld; line_det = m_ld; m_irq = 1;
                wclk(HALF);
            end
        end
        cs_n = 1'b1;
        wclk(6);
        chk(sdo_en === 1'b0, "R6 enable after transfer", sdo_en, 0);
        chk((dout & msk) === (exp & msk), "R4/R5 status bits shifted out",
            dout & msk, exp & msk);
        if (n == 8) m_ctrl = din;
        chk(ctrl_q === m_ctrl, (n == 8) ? "R2 control load" : "R3 control kept",
            ctrl_q, m_ctrl);
        chk(irq_n === !m_irq, "R8 interrupt after transfer", irq_n, !m_irq);
    endtask

    initial begin
        void'($urandom(32'd4242));
        wclk(5);
        rst = 1'b0;
        wclk(2);
        chk(ctrl_q === 8'h00, "R1 control reset", ctrl_q, 0);
        chk(irq_n === 1'b1, "R1 interrupt reset", irq_n, 1);
        chk(sdo_en === 1'b0, "R1 enable reset", sdo_en, 0);

        xfer(8'hA5, 8, -1);                        // R2 basic write
        set_status(1, 0);                          // R7
        chk(irq_n === 1'b0, "R7 interrupt on line detect", irq_n, 0);
        // R8: chip select pulse without clocks keeps interrupt
        @(negedge clk) cs_n = 1'b0; wclk(8); cs_n = 1'b1; wclk(8);
        chk(irq_n === 1'b0, "R8 no release without clock", irq_n, 0);
        xfer(8'h3C, 8, -1);
        xfer(8'hFF, 5, -1);                        // R3 short
        xfer(8'h0F, 10, -1);                       // R3 long
        // R11: clocking with chip select high
        for (int i = 0; i < 9; i++) begin
            sdi = i[0]; wclk(HALF); sclk = 1'b1; wclk(HALF); sclk = 1'b0;
        end
        wclk(6);
        chk(ctrl_q === m_ctrl, "R11 idle clocks ignored", ctrl_q, m_ctrl);
        xfer(8'h81, 8, -1);
        // R9 violation flag
        pulse_viol();
        chk(irq_n === 1'b1, "R9 violation raises no interrupt", irq_n, 1);
        xfer(8'h81, 8, -1);                        // reads bit2 = 1
        xfer(8'h81, 8, -1);                        // R10 reads bit2 = 0
        set_status(1, 1);
        xfer(8'h5A, 8, 3);                         // R5 change mid transfer
        xfer(8'h5A, 8, -1);

        for (int t = 0; t < 40; t++) begin
            int n;
            if ($urandom % 2) set_status(1'($urandom), 1'($urandom));
            if ($urandom % 3 == 0) begin
                pulse_viol();
                chk(irq_n === !m_irq, "R9 interrupt unaffected by violation", irq_n, !m_irq);
            end
            chk(irq_n === !m_irq, "R7 interrupt level before transfer", irq_n, !m_irq);
            n = ($urandom % 4 == 0) ? 3 + int'($urandom % 9) : 8;
            xfer(8'($urandom), n, ($urandom % 5 == 0) ? int'($urandom % 3) + 1 : -1);
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule